// File: doc/BRIEF.md
# Dual-Port Contention Arbiter

This block sits beside a two-port shared memory. It decides which port owns an address when both ports try to use it at the same time. Each port presents a chip enable, an address and a write strobe. When both enables are active and both addresses are equal, the block grants the location to one port. It flags the other port as busy and removes that port's write strobe before the strobe reaches the array.

A strap input selects how the block works. As a master, the block runs its own arbitration and drives the result out on the busy outputs. As a slave, it does not arbitrate. It takes the busy lines from a master device and blocks writes with them. This lets several devices share one decision when they are stacked to build a wider word.

Arbitration is clocked. The port that was already on the address in the previous cycle wins. A port keeps ownership for as long as its enable stays high and its address stays the same. A same-cycle tie goes to the left port. Only writes are blocked: the block never touches a port's chip enable.

Top module: `dpc_arbiter`

## Requirements
- R1: A contention exists only when both chip enables are high and the two addresses are equal. In every other case no busy is raised and both write strobes pass through unchanged.
- R2: In master mode, at most one busy output is high in any cycle.
- R3: When contention starts, the port that was already enabled on that same address in the previous cycle wins. The other port loses.
- R4: When both ports reach the contested address in the same cycle, the left port wins.
- R5: The winning port keeps ownership for as long as its chip enable stays high and its address stays unchanged.
- R6: In master mode the busy outputs are registered. The loser's busy output rises in the cycle after the contention begins. It falls in the cycle after the contention ends.
- R7: In master mode the losing port's write strobe is forced low in the same cycle the contention is present. The winner's strobe passes through.
- R8: In slave mode each busy output follows the busy input of the same port, and local contention raises no busy.
- R9: In slave mode a port's write strobe is forced low while its busy input is high. The other port's strobe is not affected.
- R10: During and right after reset both busy outputs are low in master mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_mode | input | 1 | Mode strap: 1 = master (local arbitration), 0 = slave (imported busy) |
| l_ce | input | 1 | Left port chip enable, active high |
| l_addr | input | ADDR_W | Left port address |
| l_we | input | 1 | Left port write strobe, active high |
| l_busy_in | input | 1 | Left busy from an external master (used in slave mode) |
| r_ce | input | 1 | Right port chip enable, active high |
| r_addr | input | ADDR_W | Right port address |
| r_we | input | 1 | Right port write strobe, active high |
| r_busy_in | input | 1 | Right busy from an external master (used in slave mode) |
| l_busy_out | output | 1 | Left port busy indication |
| r_busy_out | output | 1 | Right port busy indication |
| l_we_gated | output | 1 | Left write strobe toward the array |
| r_we_gated | output | 1 | Right write strobe toward the array |

## Verification
Write gating is combinational. It is therefore checked one nanosecond after the inputs change at the falling edge, in the same cycle as the stimulus. Busy in master mode passes through one register. It is therefore checked twice: once just before the next rising edge, where it must still show the old value, and once just after that edge, where it must show the new one. The arrival order that decides the winner comes from the enable and address captured at the previous rising edge. Each scenario therefore holds the first port for a full cycle before the second port arrives. In slave mode every result is combinational and is sampled in the stimulus cycle.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_L    = 2'd1,
    OWN_R    = 2'd2
  } owner_t;

  // Winner of a live contention: the sitting owner stays while it holds,
  // otherwise the earlier arrival wins, and a tie goes left.
  function automatic owner_t pick_winner(input owner_t cur,
                                         input logic   l_hold,
                                         input logic   r_hold);
    if (cur == OWN_L && l_hold) return OWN_L;
    if (cur == OWN_R && r_hold) return OWN_R;
    if (r_hold && !l_hold)      return OWN_R;
    return OWN_L;
  endfunction

endpackage

// File: rtl/dpc_port_track.sv
module dpc_port_track #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic [ADDR_W-1:0] addr,
  output logic              hold
);
  logic              ce_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      ce_q   <= ce;
      addr_q <= addr;
    end
  end

  // Port was already enabled on this same address one cycle ago.
  assign hold = ce && ce_q && (addr == addr_q);
endmodule

// File: rtl/dpc_owner_fsm.sv
module dpc_owner_fsm
  import dpc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   enable,
  input  logic   contend,
  input  logic   l_hold,
  input  logic   r_hold,
  output owner_t win_now,
  output owner_t owner_q
);
  always_comb begin
    if (enable && contend) win_now = pick_winner(owner_q, l_hold, r_hold);
    else                   win_now = OWN_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner_q <= OWN_NONE;
    else        owner_q <= win_now;
  end
endmodule

// File: rtl/dpc_we_gate.sv
module dpc_we_gate (
  input  logic master,
  input  logic we,
  input  logic lose_now,
  input  logic busy_in,
  output logic we_out
);
  logic block;
  assign block  = master ? lose_now : busy_in;
  assign we_out = we && !block;
endmodule

// File: rtl/dpc_arbiter.sv
module dpc_arbiter
  import dpc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              l_ce,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_we,
  input  logic              l_busy_in,
  input  logic              r_ce,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_we,
  input  logic              r_busy_in,
  output logic              l_busy_out,
  output logic              r_busy_out,
  output logic              l_we_gated,
  output logic              r_we_gated
);
  localparam int NPORT = 2;

  logic [NPORT-1:0]             ce_v, we_v, busy_in_v, hold_v, lose_v, we_out_v;
  logic [NPORT-1:0][ADDR_W-1:0] addr_v;
  logic                         contend;
  logic                         l_hold, r_hold;
  owner_t                       win_now, owner_q;

  assign ce_v      = {r_ce, l_ce};
  assign we_v      = {r_we, l_we};
  assign busy_in_v = {r_busy_in, l_busy_in};
  assign addr_v    = {r_addr, l_addr};

  assign contend = l_ce && r_ce && (l_addr == r_addr);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpc_port_track #(.ADDR_W(ADDR_W)) u_track (
      .clk  (clk),
      .rst_n(rst_n),
      .ce   (ce_v[p]),
      .addr (addr_v[p]),
      .hold (hold_v[p])
    );

    dpc_we_gate u_gate (
      .master  (master_mode),
      .we      (we_v[p]),
      .lose_now(lose_v[p]),
      .busy_in (busy_in_v[p]),
      .we_out  (we_out_v[p])
    );
  end

  assign l_hold = hold_v[0];
  assign r_hold = hold_v[1];

  dpc_owner_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (master_mode),
    .contend(contend),
    .l_hold (l_hold),
    .r_hold (r_hold),
    .win_now(win_now),
    .owner_q(owner_q)
  );

  assign lose_v[0] = (win_now == OWN_R);
  assign lose_v[1] = (win_now == OWN_L);

  assign l_busy_out = master_mode ? (owner_q == OWN_R) : l_busy_in;
  assign r_busy_out = master_mode ? (owner_q == OWN_L) : r_busy_in;
  assign l_we_gated = we_out_v[0];
  assign r_we_gated = we_out_v[1];
endmodule

// File: rtl/dpc_arbiter_chk.sv
module dpc_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic master_mode,
  input logic contend,
  input logic l_hold,
  input logic r_hold,
  input logic l_busy_in,
  input logic r_busy_in,
  input logic l_busy_out,
  input logic r_busy_out,
  input logic l_we_gated,
  input logic r_we_gated
);
  // R2
  one_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode |-> !(l_busy_out && r_busy_out));

  // R7
  one_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && contend) |-> !(l_we_gated && r_we_gated));

  // R6
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && contend) |=> (!master_mode || l_busy_out || r_busy_out));

  // R6
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !contend) |=> (!master_mode || (!l_busy_out && !r_busy_out)));

  // R5
  left_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && contend && l_hold && r_busy_out) |=> (!master_mode || r_busy_out));

  // R5
  right_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && contend && r_hold && l_busy_out) |=> (!master_mode || l_busy_out));

  // R8
  slave_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> (l_busy_out == l_busy_in && r_busy_out == r_busy_in));

  // R9
  slave_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && (l_busy_in || r_busy_in)) |->
      (!(l_busy_in && l_we_gated) && !(r_busy_in && r_we_gated)));
endmodule

bind dpc_arbiter dpc_arbiter_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .master_mode(master_mode),
  .contend    (contend),
  .l_hold     (l_hold),
  .r_hold     (r_hold),
  .l_busy_in  (l_busy_in),
  .r_busy_in  (r_busy_in),
  .l_busy_out (l_busy_out),
  .r_busy_out (r_busy_out),
  .l_we_gated (l_we_gated),
  .r_we_gated (r_we_gated)
);

// File: tb/dpc_arbiter_test.sv
`timescale 1ns/1ps
module dpc_arbiter_test;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_mode = 1'b1;
  logic l_ce = 0, l_we = 0, l_busy_in = 0;
  logic r_ce = 0, r_we = 0, r_busy_in = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_busy_out, r_busy_out, l_we_gated, r_we_gated;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dpc_arbiter #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .l_ce(l_ce), .l_addr(l_addr), .l_we(l_we), .l_busy_in(l_busy_in),
    .r_ce(r_ce), .r_addr(r_addr), .r_we(r_we), .r_busy_in(r_busy_in),
    .l_busy_out(l_busy_out), .r_busy_out(r_busy_out),
    .l_we_gated(l_we_gated), .r_we_gated(r_we_gated)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Apply inputs at the falling edge, then settle 1 ns.
  task automatic drive(input logic lc, input logic [AW-1:0] la, input logic lw,
                       input logic rc, input logic [AW-1:0] ra, input logic rw);
    @(negedge clk);
    l_ce = lc; l_addr = la; l_we = lw;
    r_ce = rc; r_addr = ra; r_we = rw;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    drive(0, '0, 0, 0, '0, 0);
    tick();
    tick();
  endtask

  task automatic t_reset();
    chk("R10", "l_busy after reset", l_busy_out, 1'b0);
    chk("R10", "r_busy after reset", r_busy_out, 1'b0);
  endtask

  task automatic t_no_contend();
    drive(1, 12'h010, 1, 1, 12'h011, 1);
    chk("R1", "l_we diff addr", l_we_gated, 1'b1);
    chk("R1", "r_we diff addr", r_we_gated, 1'b1);
    tick();
    chk("R1", "l_busy diff addr", l_busy_out, 1'b0);
    chk("R1", "r_busy diff addr", r_busy_out, 1'b0);
    drive(1, 12'h020, 1, 0, 12'h020, 1);
    chk("R1", "l_we one ce", l_we_gated, 1'b1);
    chk("R1", "r_we one ce (passes strobe)", r_we_gated, 1'b1);
    tick();
    chk("R1", "r_busy one ce", r_busy_out, 1'b0);
    idle();
  endtask

  task automatic t_left_first();
    drive(1, 12'hABC, 1, 0, '0, 0);
    tick();
    drive(1, 12'hABC, 1, 1, 12'hABC, 1);
    chk("R3", "r_we blocked, left first", r_we_gated, 1'b0);
    chk("R7", "l_we passes as winner", l_we_gated, 1'b1);
    chk("R6", "r_busy not yet", r_busy_out, 1'b0);
    tick();
    chk("R6", "r_busy one cycle later", r_busy_out, 1'b1);
    chk("R2", "l_busy low", l_busy_out, 1'b0);
    drive(1, 12'hABC, 0, 1, 12'hABC, 1);
    tick();
    tick();
    chk("R5", "left still owns", r_busy_out, 1'b1);
    chk("R5", "r_we still blocked", r_we_gated, 1'b0);
    drive(0, 12'hABC, 0, 1, 12'hABC, 1);
    chk("R7", "r_we freed same cycle", r_we_gated, 1'b1);
    chk("R6", "r_busy held until edge", r_busy_out, 1'b1);
    tick();
    chk("R6", "r_busy falls after edge", r_busy_out, 1'b0);
    idle();
  endtask

  task automatic t_right_first();
    drive(0, '0, 0, 1, 12'h3F0, 1);
    tick();
    drive(1, 12'h3F0, 1, 1, 12'h3F0, 1);
    chk("R3", "l_we blocked, right first", l_we_gated, 1'b0);
    chk("R3", "r_we passes", r_we_gated, 1'b1);
    tick();
    chk("R3", "l_busy", l_busy_out, 1'b1);
    chk("R2", "r_busy low", r_busy_out, 1'b0);
    idle();
  endtask

  task automatic t_tie();
    drive(1, 12'h777, 1, 1, 12'h777, 1);
    chk("R4", "tie: l_we passes", l_we_gated, 1'b1);
    chk("R4", "tie: r_we blocked", r_we_gated, 1'b0);
    tick();
    chk("R4", "tie: r_busy", r_busy_out, 1'b1);
    chk("R4", "tie: l_busy", l_busy_out, 1'b0);
    idle();
  endtask

  task automatic t_owner_moves();
    drive(1, 12'h100, 1, 0, '0, 0);
    tick();
    drive(1, 12'h100, 1, 1, 12'h100, 1);
    tick();
    drive(1, 12'h101, 1, 1, 12'h100, 1);
    chk("R1", "r_we free after left moves", r_we_gated, 1'b1);
    tick();
    chk("R6", "r_busy clears after move", r_busy_out, 1'b0);
    drive(1, 12'h100, 1, 1, 12'h100, 1);
    chk("R3", "left returns, right held: l_we blocked", l_we_gated, 1'b0);
    tick();
    chk("R3", "l_busy after return", l_busy_out, 1'b1);
    idle();
  endtask

  task automatic t_slave();
    master_mode = 1'b0;
    idle();
    drive(1, 12'h055, 1, 1, 12'h055, 1);
    chk("R8", "slave contention: no r_busy", r_busy_out, 1'b0);
    chk("R8", "slave contention: l_we passes", l_we_gated, 1'b1);
    chk("R8", "slave contention: r_we passes", r_we_gated, 1'b1);
    tick();
    chk("R8", "slave: l_busy stays low", l_busy_out, 1'b0);
    chk("R8", "slave: r_busy stays low", r_busy_out, 1'b0);
    @(negedge clk); l_busy_in = 1'b1; #1;
    chk("R9", "slave: l_we blocked by busy_in", l_we_gated, 1'b0);
    chk("R9", "slave: r_we unaffected", r_we_gated, 1'b1);
    chk("R8", "slave: l_busy_out follows", l_busy_out, 1'b1);
    @(negedge clk); l_busy_in = 1'b0; r_busy_in = 1'b1; #1;
    chk("R9", "slave: r_we blocked by busy_in", r_we_gated, 1'b0);
    chk("R9", "slave: l_we passes again", l_we_gated, 1'b1);
    chk("R8", "slave: r_busy_out follows", r_busy_out, 1'b1);
    @(negedge clk); r_busy_in = 1'b0;
    master_mode = 1'b1;
    idle();
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    tick();
    t_reset();
    t_no_contend();
    t_left_first();
    t_right_first();
    t_tie();
    t_owner_moves();
    t_slave();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule